// File: doc/BRIEF.md
# Two-Wire Configuration Register Slave

This block is a slave on a two-wire serial management bus. It holds a small bank of 8-bit configuration registers and lets a bus controller read or write them. Each register's current value is also presented on a wide parallel output, so the rest of the chip can use it directly.

The controller chooses the kind of access with the top bit of a command byte. With that bit set, one register is reached at the offset held in the low seven bits. With that bit clear, a counted block transfer runs from register 0 upward. Block writes carry a byte count ahead of the data. Block reads return a byte count ahead of the data. Both bus lines are open-drain: the block sees SCL and SDA as inputs and pulls SDA low through a drive-enable output.

Both lines are oversampled with the system clock, which must run several times faster than SCL. Register values are reloaded from a parameter on reset.

Top module: `smb_cfg_slave`

## Requirements
- R1: The slave acknowledges only the address byte whose upper seven bits equal DEV_ADDR (default 7'h69, i.e. bytes D2h for write and D3h for read, bit 0 = 1 meaning read). For any other address it drives no acknowledge, drives nothing, and changes no register until the next START.
- R2: A command byte with bit 7 = 1 selects single access to the register at offset bits 6:0. A data byte that follows in a write is acknowledged and stored there.
- R3: A command byte with bit 7 = 0 selects block mode. Block accesses start at register 0 and step up one register per data byte.
- R4: In a block write, the byte count and every data byte are acknowledged, and each data byte is stored in the next register.
- R5: In a block read after a repeated START, the slave first sends a byte count equal to NREG. It then sends the registers in ascending order for as long as the master acknowledges.
- R6: A byte read (address with write, command with bit 7 set, repeated START, address with read) returns the addressed register's value.
- R7: A STOP after any complete byte ends the transfer. Registers already acknowledged keep their new values, and a byte cut short by a STOP is not written.
- R8: On reset every register takes its byte of DEFAULTS (register i at bits 8i+7:8i), and SDA is released.
- R9: A START seen in the middle of a byte abandons the transfer, and the bus then accepts a fresh address byte.
- R10: Writes to offsets at or above NREG are acknowledged but change nothing. Reads from such offsets return 00h.
- R11: Bytes move most significant bit first. The slave changes its SDA drive only while SCL is low, except when releasing on START or STOP.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe | output | 1 | 1 pulls SDA low |
| regs_q | output | NREG*8 | All register contents, register i at bits 8i+7:8i |

## Verification
The main function is exercised in several ways:
- A sweep of byte writes and byte reads over every offset, including offsets just past the bank. This separates decoding of the indexed offset from out-of-range handling.
- Full block writes and block reads. These separate the count byte from the data bytes and show the ascending order.
- A block write cut by a STOP inside a byte, and a write aborted by a START inside a byte. These show which writes take effect.
- A sweep of all 127 foreign addresses. This shows the address match and that the slave stays silent afterwards.

// File: rtl/smb_cfg_slave.sv
module smb_cfg_slave #(
  parameter int               NREG     = 8,
  parameter logic [6:0]       DEV_ADDR = 7'h69,
  parameter logic [NREG*8-1:0] DEFAULTS = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  output logic [NREG*8-1:0] regs_q
);

  localparam int         IW    = (NREG > 1) ? $clog2(NREG) : 1;
  localparam logic [7:0] CNT_B = 8'(NREG);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_CMD, S_CNT, S_WDAT, S_TX, S_SKIP} st_t;

  st_t        st;
  logic [2:0] scl_p, sda_p;
  logic [7:0] sr, tx;
  logic [3:0] bitcnt;
  logic       ack_ph, blk, cnt_sent, mack;
  logic [6:0] ptr;
  logic [7:0] regs [NREG];

  logic scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev, skip_st;
  logic [7:0] rd_val, nb;

  assign scl_s    = scl_p[1];
  assign sda_s    = sda_p[1];
  assign scl_rise = scl_p[1] & ~scl_p[2];
  assign scl_fall = ~scl_p[1] & scl_p[2];
  assign start_ev = scl_p[1] & scl_p[2] & ~sda_p[1] & sda_p[2];
  assign stop_ev  = scl_p[1] & scl_p[2] & sda_p[1] & ~sda_p[2];
  assign skip_st  = (st == S_SKIP);

  assign rd_val = (int'(ptr) < NREG) ? regs[ptr[IW-1:0]] : 8'h00;
  assign nb     = (blk && !cnt_sent) ? CNT_B : rd_val;

  for (genvar g = 0; g < NREG; g++) begin : g_out
    assign regs_q[g*8 +: 8] = regs[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= 3'b111;
      sda_p <= 3'b111;
    end else begin
      scl_p <= {scl_p[1:0], scl_i};
      sda_p <= {sda_p[1:0], sda_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      sr       <= '0;
      tx       <= '0;
      bitcnt   <= '0;
      ack_ph   <= 1'b0;
      blk      <= 1'b0;
      cnt_sent <= 1'b0;
      mack     <= 1'b0;
      ptr      <= '0;
      sda_oe   <= 1'b0;
      for (int i = 0; i < NREG; i++) regs[i] <= DEFAULTS[i*8 +: 8];
    end else if (start_ev) begin
      st     <= S_ADDR;
      bitcnt <= '0;
      ack_ph <= 1'b0;
      sda_oe <= 1'b0;
    end else if (stop_ev) begin
      st     <= S_IDLE;
      bitcnt <= '0;
      ack_ph <= 1'b0;
      sda_oe <= 1'b0;
    end else begin
      case (st)
        S_ADDR, S_CMD, S_CNT, S_WDAT: begin
          if (scl_rise && !ack_ph) begin
            sr     <= {sr[6:0], sda_s};
            bitcnt <= bitcnt + 4'd1;
          end else if (scl_fall && !ack_ph && bitcnt == 4'd8) begin
            ack_ph <= 1'b1;
            sda_oe <= 1'b1;
            case (st)
              S_ADDR: begin
                if (sr[7:1] != DEV_ADDR) begin
                  st     <= S_SKIP;
                  sda_oe <= 1'b0;
                  ack_ph <= 1'b0;
                end else if (sr[0]) begin
                  st       <= S_TX;
                  cnt_sent <= 1'b0;
                  mack     <= 1'b0;
                end else begin
                  st <= S_CMD;
                end
              end
              S_CMD: begin
                blk <= ~sr[7];
                ptr <= sr[7] ? sr[6:0] : 7'd0;
                st  <= sr[7] ? S_WDAT : S_CNT;
              end
              S_CNT: st <= S_WDAT;
              default: begin
                if (int'(ptr) < NREG) regs[ptr[IW-1:0]] <= sr;
                if (ptr != 7'h7f) ptr <= ptr + 7'd1;
              end
            endcase
          end else if (scl_fall && ack_ph) begin
            ack_ph <= 1'b0;
            bitcnt <= '0;
            sda_oe <= 1'b0;
          end
        end
        S_TX: begin
          if (scl_rise && ack_ph) begin
            mack <= sda_s;
          end else if (scl_rise) begin
            bitcnt <= bitcnt + 4'd1;
          end else if (scl_fall && ack_ph) begin
            ack_ph <= 1'b0;
            bitcnt <= '0;
            if (!mack) begin
              sda_oe <= ~nb[7];
              tx     <= {nb[6:0], 1'b0};
              if (blk && !cnt_sent) cnt_sent <= 1'b1;
              else if (ptr != 7'h7f) ptr <= ptr + 7'd1;
            end else begin
              sda_oe <= 1'b0;
              st     <= S_SKIP;
            end
          end else if (scl_fall) begin
            if (bitcnt == 4'd8) begin
              sda_oe <= 1'b0;
              ack_ph <= 1'b1;
            end else begin
              sda_oe <= ~tx[7];
              tx     <= {tx[6:0], 1'b0};
            end
          end
        end
        default: sda_oe <= 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/smb_cfg_slave_chk.sv
module smb_cfg_slave_chk #(
  parameter int               NREG     = 8,
  parameter logic [NREG*8-1:0] DEFAULTS = '0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_s,
  input logic              sda_oe,
  input logic              start_ev,
  input logic              stop_ev,
  input logic              scl_fall,
  input logic              skip_st,
  input logic [NREG*8-1:0] regs_q
);

  AST_RESET_DEFAULTS: assert property (@(posedge clk) !rst_n |=> (regs_q == DEFAULTS)); // R8

  AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> (!$past(scl_s) || $past(start_ev || stop_ev))); // R11

  AST_SKIP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    skip_st |-> !sda_oe); // R1

  AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> !sda_oe); // R7

  AST_START_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> !sda_oe); // R9

  AST_REG_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(regs_q) |-> $past(scl_fall)); // R7

endmodule

bind smb_cfg_slave smb_cfg_slave_chk #(.NREG(NREG), .DEFAULTS(DEFAULTS)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_oe(sda_oe), .start_ev(start_ev),
  .stop_ev(stop_ev), .scl_fall(scl_fall), .skip_st(skip_st), .regs_q(regs_q)
);

// File: tb/smb_cfg_slave_tb.sv
`timescale 1ns/1ps
module smb_cfg_slave_tb;
  localparam int         NREG = 8;
  localparam logic [6:0] DEV  = 7'h69;
  localparam int         Q    = 50;

  function automatic logic [NREG*8-1:0] mkdef();
    logic [NREG*8-1:0] v;
    for (int i = 0; i < NREG; i++) v[i*8 +: 8] = 8'(8'h3C + 8'(i * 21));
    return v;
  endfunction
  localparam logic [NREG*8-1:0] DEFV = mkdef();

  logic clk = 0, rst_n = 0, scl = 1, sda_m = 1;
  logic sda_oe;
  logic [NREG*8-1:0] regs_q;
  wire  sda_bus = sda_m & ~sda_oe;

  always #5 clk = ~clk;

  smb_cfg_slave #(.NREG(NREG), .DEV_ADDR(DEV), .DEFAULTS(DEFV)) u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus), .sda_oe(sda_oe), .regs_q(regs_q));

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [7:0] model [NREG];
  logic [7:0] bw [16];
  logic [7:0] br [16];

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic chk_regs(string req);
    for (int i = 0; i < NREG; i++) chk(req, regs_q[i*8 +: 8], model[i]);
  endtask

  task automatic bstart();
    scl = 0; #Q; sda_m = 1; #Q; scl = 1; #Q; sda_m = 0; #Q; scl = 0; #Q;
  endtask

  task automatic bstop();
    scl = 0; #Q; sda_m = 0; #Q; scl = 1; #Q; sda_m = 1; #Q;
  endtask

  task automatic send_bit(logic b);
    scl = 0; #Q; sda_m = b; #Q; scl = 1; #(2*Q);
  endtask

  task automatic send_byte(logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    scl = 0; #Q; sda_m = 1; #Q; scl = 1; #Q; ack = !sda_bus; #Q;
  endtask

  task automatic recv_byte(output logic [7:0] b, input logic nack);
    for (int i = 7; i >= 0; i--) begin
      scl = 0; #Q; sda_m = 1; #Q; scl = 1; #Q; b[i] = sda_bus; #Q;
    end
    scl = 0; #Q; sda_m = nack; #Q; scl = 1; #(2*Q);
  endtask

  task automatic wr_byte(logic [6:0] off, logic [7:0] val, output logic ok);
    logic a0, a1, a2;
    bstart(); send_byte({DEV, 1'b0}, a0); send_byte({1'b1, off}, a1); send_byte(val, a2); bstop();
    ok = a0 & a1 & a2;
  endtask

  task automatic rd_byte(logic [6:0] off, output logic [7:0] val, output logic ok);
    logic a0, a1, a2;
    bstart(); send_byte({DEV, 1'b0}, a0); send_byte({1'b1, off}, a1);
    bstart(); send_byte({DEV, 1'b1}, a2); recv_byte(val, 1'b1); bstop();
    ok = a0 & a1 & a2;
  endtask

  task automatic blk_wr(int n, output logic ok);
    logic a;
    ok = 1;
    bstart(); send_byte({DEV, 1'b0}, a); ok &= a; send_byte(8'h00, a); ok &= a;
    send_byte(8'(n), a); ok &= a;
    for (int i = 0; i < n; i++) begin send_byte(bw[i], a); ok &= a; end
    bstop();
  endtask

  task automatic blk_rd(int n, output logic [7:0] cnt, output logic ok);
    logic a0, a1, a2;
    bstart(); send_byte({DEV, 1'b0}, a0); send_byte(8'h00, a1);
    bstart(); send_byte({DEV, 1'b1}, a2); recv_byte(cnt, 1'b0);
    for (int i = 0; i < n; i++) recv_byte(br[i], (i == n - 1));
    bstop();
    ok = a0 & a1 & a2;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic ok, a;
    logic [7:0] v, cnt;
    for (int i = 0; i < NREG; i++) model[i] = DEFV[i*8 +: 8];
    #37; rst_n = 1; #100;

    chk_regs("R8 reset defaults");
    chk("R8 sda released", sda_oe, 0);

    for (int off = 0; off < NREG + 2; off++) begin
      rd_byte(7'(off), v, ok);
      chk("R6 byte read acks", ok, 1);
      chk("R6 R11 R10 byte read value", v, (off < NREG) ? model[off] : 8'h00);
    end

    for (int off = 0; off < NREG; off++) begin
      v = 8'(off * 37 + 5) ^ 8'hA5;
      wr_byte(7'(off), v, ok);
      model[off] = v;
      chk("R2 byte write acks", ok, 1);
      chk_regs("R2 byte write regs");
    end
    for (int off = 0; off < NREG; off++) begin
      rd_byte(7'(off), v, ok);
      chk("R2 R6 readback", v, model[off]);
    end

    wr_byte(7'(NREG), 8'hEE, ok);
    chk("R10 out-of-range write acked", ok, 1);
    wr_byte(7'h7f, 8'h77, ok);
    chk("R10 top offset write acked", ok, 1);
    chk_regs("R10 out-of-range write ignored");

    for (int i = 0; i < NREG; i++) bw[i] = 8'(200 - i * 13);
    blk_wr(NREG, ok);
    for (int i = 0; i < NREG; i++) model[i] = bw[i];
    chk("R4 block write acks", ok, 1);
    chk_regs("R3 R4 block write regs");

    blk_rd(NREG + 1, cnt, ok);
    chk("R5 block read acks", ok, 1);
    chk("R5 block read count", cnt, NREG);
    for (int i = 0; i < NREG; i++) chk("R3 R5 block read data", br[i], model[i]);
    chk("R10 block read past end", br[NREG], 8'h00);

    bstart(); send_byte({DEV, 1'b0}, a); send_byte(8'h00, a); send_byte(8'd6, a);
    for (int i = 0; i < 3; i++) begin
      send_byte(8'h90 + 8'(i), a); model[i] = 8'h90 + 8'(i);
      chk("R7 partial block ack", a, 1);
    end
    send_bit(1); send_bit(0); send_bit(1); send_bit(1);
    bstop();
    chk_regs("R7 stop after complete bytes");

    bstart(); send_byte({DEV, 1'b0}, a); send_byte(8'h81, a);
    send_bit(0); send_bit(1); send_bit(0);
    bstart(); send_byte({DEV, 1'b0}, a); send_byte(8'h82, a); send_byte(8'h5A, a); bstop();
    model[2] = 8'h5A;
    chk("R9 restart after abort acked", a, 1);
    chk_regs("R9 abort discards partial byte");

    for (int ad = 0; ad < 128; ad++) begin
      if (ad != DEV) begin
        bstart(); send_byte({7'(ad), 1'b0}, a);
        chk("R1 foreign address no ack", a, 0);
        if (ad % 32 == 0) begin
          send_byte(8'h83, a); chk("R1 ignored command no ack", a, 0);
          send_byte(8'hFF, a); chk("R1 ignored data no ack", a, 0);
        end
        bstop();
      end
    end
    chk_regs("R1 foreign traffic left regs");

    finish_run();
  end
endmodule